// File: doc/BRIEF.md
# Oscillator Fail Flag and Output Control

This block watches a slow timekeeping oscillator from a fast system clock domain and keeps a sticky fail flag. The flag tells software whether the time and date counters can be trusted. It is set at power-up, whenever software halts the oscillator through the stop bit, and whenever the oscillator input stops producing rising edges. The flag is cleared only when software explicitly writes a zero to it.

The block also holds two other register bits. The first is the stop bit, which halts the oscillator. The second is an output-level bit that controls an open-drain general-purpose pin through an active-low pull-down enable. Register writes arrive as per-register strobes with a data byte. Only bit 7 of each byte is used here. The surrounding register file owns the other bits.

Loss of oscillator is judged by counting system clocks since the last rising edge of the synchronized oscillator input. The count is compared against a limit that software sets at run time.

Top module: `osc_fail_ctl`

## Requirements
- R1: After reset the fail flag reads 1, the stop bit reads 0 and `pinPullN` reads 1 (pin released).
- R2: A minutes-register write whose bit 7 is 0 clears the fail flag on the next clock edge, provided no set condition holds in that cycle.
- R3: A minutes-register write whose bit 7 is 1 leaves the fail flag unchanged, whether the flag is 0 or 1.
- R4: A seconds-register write loads the stop bit from data bit 7 on the next edge. While the stop bit is 1, the fail flag is 1 from the following cycle on.
- R5: If no rising edge of the synchronized oscillator is seen for `lossLimit` system clocks, the fail flag is set. An oscillator whose rising edges come closer together than `lossLimit` clocks never sets it.
- R6: When a clearing write coincides with a set condition (stop bit 1, or loss detected), the flag stays 1.
- R7: A control-register write loads the output level from data bit 7. `pinPullN` is 0 (pin pulled low) when the level is 0, and 1 (released) when the level is 1.
- R8: Data bits 6 to 0 of the seconds, minutes and control writes have no effect on any output of this block.
- R9: The fail flag stays at 1 after the oscillator resumes, until a clearing write arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rstN | input | 1 | Active-low power-on reset |
| oscIn | input | 1 | Raw oscillator signal, asynchronous to clk |
| lossLimit | input | LIMIT_W | System clocks without a rising edge before loss is declared |
| secWrEn | input | 1 | Write strobe for the seconds register (stop bit) |
| secWrData | input | 8 | Seconds write data, bit 7 is the stop bit |
| minWrEn | input | 1 | Write strobe for the minutes register (fail flag) |
| minWrData | input | 8 | Minutes write data, bit 7 is the fail flag |
| ctlWrEn | input | 1 | Write strobe for the control register |
| ctlWrData | input | 8 | Control write data, bit 7 is the output level |
| oscFail | output | 1 | Sticky oscillator fail flag |
| stopBit | output | 1 | Oscillator stop request |
| pinPullN | output | 1 | Active-low pull-down enable for the open-drain pin |

## Verification
The assertions assume that `lossLimit` is nonzero and larger than the oscillator period measured in system clocks. They also assume that write strobes are sampled synchronously to `clk` with their data held stable in the same cycle. The stimulus meets these assumptions by running the oscillator with an eight-clock period and using limits of 30 and, for one deliberate trip, 3. Limit changes are made only while the flag is expected to go high anyway. Writes are driven on the falling clock edge for exactly one cycle.

// File: rtl/osc_fail_pkg.sv
package osc_fail_pkg;
  // bit position of the register field handled by this block, in every byte
  localparam int FIELD_BIT = 7;

  // strobes handed from control to datapath
  typedef struct packed {
    logic failSet;
    logic failClr;
    logic stopLoad;
    logic stopVal;
    logic outLoad;
    logic outVal;
  } regStrobe_t;
endpackage

// File: rtl/osc_fail_ctrl.sv
module osc_fail_ctrl
  import osc_fail_pkg::*;
(
  input  logic       secWrEn,
  input  logic [7:0] secWrData,
  input  logic       minWrEn,
  input  logic [7:0] minWrData,
  input  logic       ctlWrEn,
  input  logic [7:0] ctlWrData,
  input  logic       stopBit,
  input  logic       oscLost,
  output regStrobe_t strobe
);
  logic setCond;
  logic clrReq;

  always_comb begin
    // any reason the oscillator cannot be trusted in this cycle
    setCond = stopBit | oscLost;
    clrReq  = minWrEn & ~minWrData[FIELD_BIT];

    strobe          = '0;
    strobe.failSet  = setCond;
    // set has priority over a coincident clearing write
    strobe.failClr  = clrReq & ~setCond;
    strobe.stopLoad = secWrEn;
    strobe.stopVal  = secWrData[FIELD_BIT];
    strobe.outLoad  = ctlWrEn;
    strobe.outVal   = ctlWrData[FIELD_BIT];
  end
endmodule

// File: rtl/osc_fail_dp.sv
module osc_fail_dp
  import osc_fail_pkg::*;
#(
  parameter int LIMIT_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               oscIn,
  input  logic [LIMIT_W-1:0] lossLimit,
  input  regStrobe_t         strobe,
  output logic               oscLost,
  output logic               oscFail,
  output logic               stopBit,
  output logic               outLevel
);
  localparam logic [LIMIT_W-1:0] CNT_ONE = LIMIT_W'(1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   oscPrev;
  logic                   oscRise;
  logic [LIMIT_W-1:0]     idleCnt;

  // synchronizer chain for the asynchronous oscillator input
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], oscIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) oscPrev <= 1'b0;
    else       oscPrev <= syncChain[SYNC_STAGES-1];
  end

  assign oscRise = syncChain[SYNC_STAGES-1] & ~oscPrev;

  // clocks since the last rising edge, saturating at the limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  idleCnt <= '0;
    else if (oscRise)           idleCnt <= '0;
    else if (idleCnt < lossLimit) idleCnt <= idleCnt + CNT_ONE;
  end

  assign oscLost = (idleCnt >= lossLimit);

  // sticky fail flag, powers up set
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               oscFail <= 1'b1;
    else if (strobe.failSet) oscFail <= 1'b1;
    else if (strobe.failClr) oscFail <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                stopBit <= 1'b0;
    else if (strobe.stopLoad) stopBit <= strobe.stopVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               outLevel <= 1'b1;
    else if (strobe.outLoad) outLevel <= strobe.outVal;
  end
endmodule

// File: rtl/osc_fail_ctl.sv
module osc_fail_ctl
  import osc_fail_pkg::*;
#(
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               oscIn,
  input  logic [LIMIT_W-1:0] lossLimit,
  input  logic               secWrEn,
  input  logic [7:0]         secWrData,
  input  logic               minWrEn,
  input  logic [7:0]         minWrData,
  input  logic               ctlWrEn,
  input  logic [7:0]         ctlWrData,
  output logic               oscFail,
  output logic               stopBit,
  output logic               pinPullN
);
  regStrobe_t strobe;
  logic       oscLost;
  logic       outLevel;

  osc_fail_ctrl ctrl_i (
    .secWrEn  (secWrEn),
    .secWrData(secWrData),
    .minWrEn  (minWrEn),
    .minWrData(minWrData),
    .ctlWrEn  (ctlWrEn),
    .ctlWrData(ctlWrData),
    .stopBit  (stopBit),
    .oscLost  (oscLost),
    .strobe   (strobe)
  );

  osc_fail_dp #(.LIMIT_W(LIMIT_W), .SYNC_STAGES(2)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .oscIn    (oscIn),
    .lossLimit(lossLimit),
    .strobe   (strobe),
    .oscLost  (oscLost),
    .oscFail  (oscFail),
    .stopBit  (stopBit),
    .outLevel (outLevel)
  );

  // open drain: a low level enables the pull-down
  assign pinPullN = outLevel;
endmodule

// File: rtl/osc_fail_chk.sv
module osc_fail_chk (
  input logic       clk,
  input logic       rstN,
  input logic       secWrEn,
  input logic [7:0] secWrData,
  input logic       minWrEn,
  input logic [7:0] minWrData,
  input logic       ctlWrEn,
  input logic [7:0] ctlWrData,
  input logic       oscFail,
  input logic       stopBit,
  input logic       pinPullN
);
  a_r4_stop_forces_fail: assert property (@(posedge clk) disable iff (!rstN)
    stopBit |=> oscFail);

  a_r4_stop_loads: assert property (@(posedge clk) disable iff (!rstN)
    secWrEn |=> (stopBit == $past(secWrData[7])));

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (oscFail && !(minWrEn && !minWrData[7])) |=> oscFail);

  a_r2_fall_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    $fell(oscFail) |-> $past(minWrEn && !minWrData[7]));

  a_r6_stop_beats_clear: assert property (@(posedge clk) disable iff (!rstN)
    (minWrEn && !minWrData[7] && stopBit) |=> oscFail);

  a_r7_pin_loads: assert property (@(posedge clk) disable iff (!rstN)
    ctlWrEn |=> (pinPullN == $past(ctlWrData[7])));

  a_r7_pin_holds: assert property (@(posedge clk) disable iff (!rstN)
    !ctlWrEn |=> $stable(pinPullN));
endmodule

bind osc_fail_ctl osc_fail_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .secWrEn  (secWrEn),
  .secWrData(secWrData),
  .minWrEn  (minWrEn),
  .minWrData(minWrData),
  .ctlWrEn  (ctlWrEn),
  .ctlWrData(ctlWrData),
  .oscFail  (oscFail),
  .stopBit  (stopBit),
  .pinPullN (pinPullN)
);

// File: tb/osc_fail_ctl_tb.sv
`timescale 1ns/1ps
module osc_fail_ctl_tb_top;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          oscIn = 1'b0;
  logic          oscRun = 1'b0;
  logic [LW-1:0] lossLimit = LW'(30);
  logic          secWrEn = 1'b0, minWrEn = 1'b0, ctlWrEn = 1'b0;
  logic [7:0]    secWrData = '0, minWrData = '0, ctlWrData = '0;
  logic          oscFail, stopBit, pinPullN;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  osc_fail_ctl #(.LIMIT_W(LW)) dut_i (
    .clk(clk), .rstN(rstN), .oscIn(oscIn), .lossLimit(lossLimit),
    .secWrEn(secWrEn), .secWrData(secWrData),
    .minWrEn(minWrEn), .minWrData(minWrData),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .oscFail(oscFail), .stopBit(stopBit), .pinPullN(pinPullN)
  );

  // oscillator model: period of 8 system clocks while running
  initial forever begin
    repeat (4) @(posedge clk);
    if (oscRun) oscIn <= ~oscIn;
  end

  task automatic chk(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_sec(input logic [7:0] d);
    secWrEn = 1'b1; secWrData = d; @(negedge clk); secWrEn = 1'b0;
  endtask
  task automatic wr_min(input logic [7:0] d);
    minWrEn = 1'b1; minWrData = d; @(negedge clk); minWrEn = 1'b0;
  endtask
  task automatic wr_ctl(input logic [7:0] d);
    ctlWrEn = 1'b1; ctlWrData = d; @(negedge clk); ctlWrEn = 1'b0;
  endtask

  task automatic t_reset;
    chk(oscFail, 1'b1, "R1 fail flag after reset");
    chk(stopBit, 1'b0, "R1 stop bit after reset");
    chk(pinPullN, 1'b1, "R1 pin released after reset");
  endtask

  task automatic t_clear;
    oscRun = 1'b1;
    wait_clk(30);
    wr_min(8'h7F);
    chk(oscFail, 1'b0, "R2 clear with bit7=0 (R8 low bits ignored)");
    wr_min(8'h80);
    chk(oscFail, 1'b0, "R3 write of 1 keeps flag 0");
    wait_clk(60);
    chk(oscFail, 1'b0, "R5 running oscillator never sets flag");
  endtask

  task automatic t_output;
    wr_ctl(8'h00);
    chk(pinPullN, 1'b0, "R7 level 0 pulls pin low");
    wr_ctl(8'h7F);
    chk(pinPullN, 1'b0, "R8 control low bits ignored");
    wr_ctl(8'h80);
    chk(pinPullN, 1'b1, "R7 level 1 releases pin");
    wr_ctl(8'h7F);
    wr_ctl(8'hFF);
    chk(pinPullN, 1'b1, "R8 control low bits ignored at level 1");
    chk(oscFail, 1'b0, "R8 control write leaves fail flag");
  endtask

  task automatic t_stop;
    wr_sec(8'h80);
    chk(stopBit, 1'b1, "R4 stop bit loaded");
    wait_clk(1);
    chk(oscFail, 1'b1, "R4 stop sets fail flag");
    wr_min(8'h00);
    chk(oscFail, 1'b1, "R6 clear loses against stop");
    wr_sec(8'h7F);
    chk(stopBit, 1'b0, "R8 seconds low bits ignored, stop cleared");
    wr_min(8'h80);
    chk(oscFail, 1'b1, "R3 write of 1 keeps flag 1");
    wr_min(8'h00);
    chk(oscFail, 1'b0, "R2 clear after stop released");
  endtask

  task automatic t_loss;
    oscRun = 1'b0;
    wait_clk(8);
    chk(oscFail, 1'b0, "R5 short gap below limit");
    wait_clk(60);
    chk(oscFail, 1'b1, "R5 loss of edges sets flag");
    wr_min(8'h00);
    chk(oscFail, 1'b1, "R6 clear loses against loss");
    oscRun = 1'b1;
    wait_clk(40);
    chk(oscFail, 1'b1, "R9 flag sticky after oscillator resumes");
    wr_min(8'h00);
    chk(oscFail, 1'b0, "R2 clear after resume");
  endtask

  task automatic t_limit;
    lossLimit = LW'(3);
    wait_clk(30);
    chk(oscFail, 1'b1, "R5 limit below period trips flag");
    lossLimit = LW'(30);
    wait_clk(20);
    wr_min(8'h00);
    chk(oscFail, 1'b0, "R5 clear once limit restored");
  endtask

  initial begin
    wait_clk(3);
    rstN = 1'b1;
    wait_clk(1);
    t_reset();
    t_clear();
    t_output();
    t_stop();
    t_loss();
    t_limit();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #200_000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule